// File: doc/BRIEF.md
# Sigma-Delta Phase Accumulator NCO

This block turns a signed tuning word into a steady stream of phase-interpolator codes, acting as a numerically controlled oscillator built on a fixed-frequency clock. It holds a wrapping phase code. At a fixed cadence, a first-order sigma-delta modulator decides whether the code moves down, moves up or holds. The modulator integrates the tuning word, so the average rate of code movement, and with it the frequency offset of the interpolated clock, is proportional to that word. Moving the code down gives a positive offset and moving it up gives a negative one.

Each new code is delivered to the interpolator through a register-write port. The port has an enable, a write-enable, an address and a data word, and a ready input acknowledges each write. Only one write is ever outstanding. An update that arrives while the port is busy is folded into the next write, so that write carries the most recent code. The step size per move is a run-time input, and the number of codes per unit interval is a parameter.

Top module: `sd_phase_nco`

## Requirements
- R1: While `rst_ni` is low, and until the first update, `phase_o` is 0, the modulator residue is 0 and `wr_en_o` stays low.
- R2: `upd_o` pulses for one cycle once every `WR_TIME` clock cycles (default 5). The phase code and the modulator change only in the cycle after such a pulse.
- R3: On each update the residue r (0 ≤ r < 2^21) becomes s = r + `tune_i`. If s ≥ 2^21, the code moves down and r = s − 2^21. If s < 0, the code moves up and r = s + 2^21. Otherwise the code holds and r = s.
- R4: A tuning word of −2^21 moves the code up on every update. A tuning word of 0 never moves it.
- R5: The code wraps modulo `PI_RES` (default 248) in both directions, and `phase_o` is always below `PI_RES`.
- R6: A `step_i` of 0 leaves the code unchanged on every update.
- R7: Each move is `step_i` codes. Values above 7 move by 7.
- R8: Each write is a one-cycle `wr_en_o` pulse with `wr_we_o` high and `wr_addr_o` = 0x4C. `wr_data_o[7:0]` holds the phase code as it stood in the cycle before the pulse, and `wr_data_o[15:8]` is 0.
- R9: Every update requests a write. No new `wr_en_o` is issued until `wr_rdy_i` has acknowledged the previous write.
- R10: Updates that arrive while a write is outstanding are merged. Fewer writes than updates are issued, and once the port drains, the last write carries the current code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tune_i | input | 22 | Signed tuning word |
| step_i | input | 4 | Codes per move (0 = frozen, >7 = 7) |
| wr_rdy_i | input | 1 | Write acknowledge |
| wr_en_o | output | 1 | Write strobe |
| wr_we_o | output | 1 | Write-enable |
| wr_addr_o | output | 8 | Interpolator register address |
| wr_data_o | output | 16 | Write data (phase code in low byte) |
| phase_o | output | 8 | Current phase code |
| upd_o | output | 1 | Update enable pulse |

## Verification
Two events can land in the same cycle: a phase update, and the issue of a write that was merged earlier. When that happens the write must carry the code from before the update, and the newer code must leave a fresh request behind. The bench provokes this collision by holding the acknowledge back for longer than the update period. It judges every write against the code it observed one cycle earlier, and after the port drains it checks that the last write matches the live code.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2
  } move_e;
endpackage

// File: rtl/nco_cadence.sv
module nco_cadence #(
  parameter int WR_TIME = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic upd_o
);
  localparam int CW = (WR_TIME > 1) ? $clog2(WR_TIME) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last  = (cnt_q == CW'(WR_TIME - 1));
  assign upd_o = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (last) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nco_sdm.sv
module nco_sdm
  import nco_pkg::*;
#(
  parameter int TUNE_W = 22
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_i,
  input  logic signed [TUNE_W-1:0] tune_i,
  output move_e                    move_o
);
  localparam int FW = TUNE_W - 1;

  logic [FW-1:0]   err_q;
  logic [TUNE_W:0] sum;
  logic            carry, borrow;

  // residue in [0,2^FW); sum sign bit = borrow, bit FW = carry
  assign sum    = {2'b00, err_q} + {tune_i[TUNE_W-1], tune_i};
  assign borrow = sum[TUNE_W];
  assign carry  = !sum[TUNE_W] && sum[FW];

  always_comb begin
    if (carry)       move_o = MV_DOWN;
    else if (borrow) move_o = MV_UP;
    else             move_o = MV_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= '0;
    else if (upd_i) err_q <= sum[FW-1:0];
  end
endmodule

// File: rtl/nco_phase.sv
module nco_phase
  import nco_pkg::*;
#(
  parameter int ACC_W    = 8,
  parameter int PI_RES   = 248,
  parameter int STEP_W   = 4,
  parameter int MAX_STEP = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  move_e             move_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [ACC_W-1:0]  phase_o
);
  localparam int SW = ACC_W + 1;

  logic [ACC_W-1:0]  phase_q, phase_d;
  logic [STEP_W-1:0] stp;
  logic [SW-1:0]     p_ext, s_ext, up_sum, dn_val;

  assign stp    = (step_i > STEP_W'(MAX_STEP)) ? STEP_W'(MAX_STEP) : step_i;
  assign p_ext  = {1'b0, phase_q};
  assign s_ext  = SW'(stp);
  assign up_sum = p_ext + s_ext;
  assign dn_val = (p_ext >= s_ext) ? (p_ext - s_ext) : (p_ext + SW'(PI_RES) - s_ext);

  always_comb begin
    unique case (move_i)
      MV_UP:   phase_d = (up_sum >= SW'(PI_RES)) ? ACC_W'(up_sum - SW'(PI_RES))
                                                 : ACC_W'(up_sum);
      MV_DOWN: phase_d = ACC_W'(dn_val);
      default: phase_d = phase_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (upd_i) phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/nco_wr_port.sv
module nco_wr_port #(
  parameter int              ACC_W   = 8,
  parameter int              ADDR_W  = 8,
  parameter int              DATA_W  = 16,
  parameter logic [ADDR_W-1:0] PI_ADDR = 8'h4C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [ACC_W-1:0]  phase_i,
  input  logic              rdy_i,
  output logic              en_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic             en_q, busy_q, pend_q;
  logic [ACC_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      code_q <= '0;
    end else begin
      en_q <= 1'b0;
      if (busy_q) begin
        if (rdy_i) busy_q <= 1'b0;
      end else if (pend_q) begin
        en_q   <= 1'b1;
        busy_q <= 1'b1;
        pend_q <= 1'b0;
        code_q <= phase_i;
      end
      // a new update always leaves a request; overrides the clear above
      if (upd_i) pend_q <= 1'b1;
    end
  end

  assign en_o   = en_q;
  assign we_o   = en_q;
  assign addr_o = PI_ADDR;

  generate
    if (DATA_W > ACC_W) begin : g_pad
      assign data_o = {{(DATA_W - ACC_W){1'b0}}, code_q};
    end else begin : g_cut
      assign data_o = code_q[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sd_phase_nco.sv
module sd_phase_nco
  import nco_pkg::*;
#(
  parameter int                TUNE_W   = 22,
  parameter int                ACC_W    = 8,
  parameter int                PI_RES   = 248,
  parameter int                WR_TIME  = 5,
  parameter int                STEP_W   = 4,
  parameter int                MAX_STEP = 7,
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-1:0] PI_ADDR  = 8'h4C
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [TUNE_W-1:0] tune_i,
  input  logic [STEP_W-1:0]        step_i,
  input  logic                     wr_rdy_i,
  output logic                     wr_en_o,
  output logic                     wr_we_o,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [DATA_W-1:0]        wr_data_o,
  output logic [ACC_W-1:0]         phase_o,
  output logic                     upd_o
);
  logic  upd;
  move_e move;

  nco_cadence #(.WR_TIME(WR_TIME)) i_cadence (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_o (upd)
  );

  nco_sdm #(.TUNE_W(TUNE_W)) i_sdm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (upd),
    .tune_i(tune_i),
    .move_o(move)
  );

  nco_phase #(
    .ACC_W(ACC_W), .PI_RES(PI_RES), .STEP_W(STEP_W), .MAX_STEP(MAX_STEP)
  ) i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .move_i (move),
    .step_i (step_i),
    .phase_o(phase_o)
  );

  nco_wr_port #(
    .ACC_W(ACC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PI_ADDR(PI_ADDR)
  ) i_wr_port (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .phase_i(phase_o),
    .rdy_i  (wr_rdy_i),
    .en_o   (wr_en_o),
    .we_o   (wr_we_o),
    .addr_o (wr_addr_o),
    .data_o (wr_data_o)
  );

  assign upd_o = upd;
endmodule

// File: rtl/nco_chk.sv
module nco_chk #(
  parameter int ACC_W  = 8,
  parameter int PI_RES = 248
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             upd_o,
  input logic [ACC_W-1:0] phase_o,
  input logic             wr_en_o,
  input logic             wr_we_o,
  input logic             wr_rdy_i
);
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q <= 1'b0;
    else if (wr_en_o)  out_q <= !wr_rdy_i;
    else if (wr_rdy_i) out_q <= 1'b0;
  end

  // R2
  upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  // R2
  phase_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |=> $stable(phase_o));

  // R5
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o < ACC_W'(PI_RES));

  // R8
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  // R8
  wr_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_we_o);

  // R9
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q |-> !wr_en_o);
endmodule

bind sd_phase_nco nco_chk #(.ACC_W(ACC_W), .PI_RES(PI_RES)) i_nco_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .upd_o   (upd_o),
  .phase_o (phase_o),
  .wr_en_o (wr_en_o),
  .wr_we_o (wr_we_o),
  .wr_rdy_i(wr_rdy_i)
);

// File: tb/test_sd_phase_nco.sv
module test_sd_phase_nco;
  localparam int RES   = 248;
  localparam int WRT   = 5;
  localparam int HALF  = 1 << 21;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [21:0] tune = '0;
  logic [3:0]         step = 4'd1;
  logic               rdy = 1'b0;
  logic               wr_en, wr_we, upd;
  logic [7:0]         wr_addr, phase;
  logic [15:0]        wr_data;

  int n_chk = 0, n_fail = 0;
  int lat_cfg = 2, lat = 0;
  bit outst = 0;
  int n_upd = 0, n_wr = 0, gap = -1;
  int prev_phase = 0, last_wr = 0;
  longint m_err = 0;
  int m_phase = 0;

  always #10 clk = ~clk;

  sd_phase_nco i_sd_phase_nco (
    .clk_i(clk), .rst_ni(rst_n), .tune_i(tune), .step_i(step), .wr_rdy_i(rdy),
    .wr_en_o(wr_en), .wr_we_o(wr_we), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .phase_o(phase), .upd_o(upd)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model of R3/R5/R7, port responder and write monitor
  always @(negedge clk) begin
    rdy = 1'b0;
    if (!rst_n) begin
      m_err = 0; m_phase = 0; gap = -1; outst = 0; lat = 0;
    end else begin
      chk(phase == m_phase, "R3", phase, m_phase);
      if (wr_en) begin
        n_wr++;
        chk(!outst, "R9", outst, 0);
        chk(wr_we && wr_addr == 8'h4C, "R8", wr_addr, 8'h4C);
        chk(wr_data == 16'(prev_phase), "R8", wr_data, prev_phase);
        last_wr = wr_data;
        outst = 1; lat = lat_cfg;
      end else if (lat > 0) begin
        lat--;
        if (lat == 0) begin rdy = 1'b1; outst = 0; end
      end
      if (gap >= 0) gap++;
      if (upd) begin
        longint s;
        int st;
        n_upd++;
        if (gap >= 0) chk(gap == WRT, "R2", gap, WRT);
        gap = 0;
        st = (step > 7) ? 7 : int'(step);
        s = m_err + longint'(tune);
        if (s >= HALF) begin
          m_err = s - HALF; m_phase = (m_phase - st + RES) % RES;
        end else if (s < 0) begin
          m_err = s + HALF; m_phase = (m_phase + st) % RES;
        end else m_err = s;
      end
      prev_phase = phase;
    end
  end

  task automatic set_in(input int t, input int s);
    @(posedge clk); #2;
    tune = 22'(t); step = 4'(s);
  endtask

  task automatic wait_upd(input int k);
    for (int i = 0; i < k; i++) begin
      do @(negedge clk); while (!upd);
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(phase == 0 && !wr_en, "R1", phase, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!wr_en && phase == 0 && !upd, "R1", wr_en, 0);
    end
  endtask

  task automatic t_zero;
    int p0;
    set_in(0, 3); wait_upd(1); p0 = phase;
    wait_upd(10);
    chk(phase == p0, "R4", phase, p0);
  endtask

  task automatic t_full_up;
    int p0;
    set_in(-HALF, 2); wait_upd(1); p0 = phase;
    wait_upd(6);
    chk(phase == (p0 + 12) % RES, "R4", phase, (p0 + 12) % RES);
    wait_upd(130);
    chk(phase == (p0 + 272) % RES, "R5", phase, (p0 + 272) % RES);
  endtask

  task automatic t_half;
    int p0;
    set_in(HALF / 2, 1); wait_upd(1); p0 = phase;
    wait_upd(8);
    chk(phase == (p0 - 4 + RES) % RES, "R3", phase, (p0 - 4 + RES) % RES);
  endtask

  task automatic t_down_wrap;
    set_in(HALF - 1, 7);
    wait_upd(80);
    chk(phase < RES, "R5", phase, RES - 1);
  endtask

  task automatic t_step_zero;
    int p0, w0;
    set_in(-HALF, 0); wait_upd(1); p0 = phase; w0 = n_wr;
    wait_upd(10);
    chk(phase == p0, "R6", phase, p0);
    chk(n_wr - w0 >= 9, "R9", n_wr - w0, 10);
  endtask

  task automatic t_clamp;
    int p0;
    set_in(-HALF, 13); wait_upd(1); p0 = phase;
    wait_upd(10);
    chk(phase == (p0 + 70) % RES, "R7", phase, (p0 + 70) % RES);
  endtask

  task automatic t_merge;
    int u0, w0;
    lat_cfg = 12;
    set_in(-HALF, 3); wait_upd(1); u0 = n_upd; w0 = n_wr;
    wait_upd(20);
    chk(n_wr - w0 < n_upd - u0 && n_wr - w0 > 0, "R10", n_wr - w0, n_upd - u0);
    lat_cfg = 2;
    set_in(-HALF, 0);
    wait_upd(6); repeat (3) @(negedge clk);
    chk(last_wr == phase, "R10", last_wr, phase);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_full_up();
    t_half();
    t_down_wrap();
    t_step_zero();
    t_clamp();
    t_merge();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule